// File: doc/BRIEF.md
# Universal Shift Register with Shared Bidirectional Data Pins

This block is a storage and shift register whose parallel inputs and parallel outputs use one common set of tri-state pins. A two-bit mode select chooses one of four clock-edge actions: keep the current contents, shift toward the high end, shift toward the low end, or capture the value present on the shared pins. Each shift direction takes its new end bit from its own serial input.

The lowest and highest register bits also leave the block on two dedicated serial outputs. Several blocks can therefore be chained, and the end bits remain visible while the shared pins are released. An active-low clear empties the register at once and does not wait for the clock. The shared pins are driven only when both active-low output enables are asserted and the block is not loading. During a load the pins are released, so another agent can put the load value on them.

Top module: `univ_shift_reg`

## Requirements
- R1: While `clr_n` is low, every register bit is 0 within the same clock period, with no clock edge needed, so `ser_out_lo` and `ser_out_hi` read 0.
- R2: With `sel` = 2'b00, a clock edge leaves every register bit unchanged.
- R3: With `sel` = 2'b01, a clock edge moves bit n to bit n+1 and loads `ser_in_lo` into bit 0.
- R4: With `sel` = 2'b10, a clock edge moves bit n to bit n-1 and loads `ser_in_hi` into bit W-1.
- R5: With `sel` = 2'b11, a clock edge copies the value on `pio` into the register, with bit i of `pio` going to register bit i.
- R6: `pio` carries the register contents when `oe_a_n` and `oe_b_n` are both 0 and `sel` is not 2'b11. Otherwise every `pio` driver of the block is off (high impedance), so a value driven from outside is read back unchanged.
- R7: `ser_out_lo` always equals register bit 0 and `ser_out_hi` always equals bit W-1, whatever the state of the output enables and the mode.
- R8: A low `clr_n` wins over every mode. A clock edge that occurs while `clr_n` is low leaves the register at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| sel | input | 2 | Mode: 00 hold, 01 shift up, 10 shift down, 11 load |
| ser_in_lo | input | 1 | Serial bit entering bit 0 on shift up |
| ser_in_hi | input | 1 | Serial bit entering bit W-1 on shift down |
| oe_a_n | input | 1 | Output enable A, active low |
| oe_b_n | input | 1 | Output enable B, active low |
| pio | inout | W | Shared parallel load input and tri-state parallel output |
| ser_out_lo | output | 1 | Register bit 0 |
| ser_out_hi | output | 1 | Register bit W-1 |

## Verification
The hardest situation to reach is a load or a released-pin phase in which the register's contents cannot be seen on the pins. Only the two serial outputs show anything, and a fault there could stay hidden until the pins are enabled again. The stimulus therefore follows every load and every disabled phase with hold cycles that have the enables asserted. It also drives an outside value on the pins only while the block's drivers should be off. In those phases the outside value must be read back unchanged, which exposes contention. Clear pulses are applied between clock edges and held across an edge during an active shift, to check that the clear acts at once and that it overrides the mode.

// File: rtl/usr_pkg.sv
// Package: shared types for the universal shift register.
// Assumes a two-bit mode select whose code values are fixed by the pin protocol.
package usr_pkg;
    typedef enum logic [1:0] {
        MODE_HOLD = 2'b00,
        MODE_SHUP = 2'b01,
        MODE_SHDN = 2'b10,
        MODE_LOAD = 2'b11
    } usr_mode_t;
endpackage

// File: rtl/usr_ctrl.sv
// Control decode: turns the raw select into a mode and decides whether the
// shared pins are driven. Assumes both output enables are active low.
module usr_ctrl
    import usr_pkg::*;
(
    input  logic [1:0] sel,
    input  logic       oe_a_n,
    input  logic       oe_b_n,
    output usr_mode_t  mode,
    output logic       drv_en
);
    // Purpose: map select code to mode, and release the pins during a load.
    always_comb begin
        mode   = usr_mode_t'(sel);
        drv_en = !oe_a_n && !oe_b_n && (mode != MODE_LOAD);
    end
endmodule

// File: rtl/usr_bit_cell.sv
// One storage bit: picks its next value from itself, its lower neighbour,
// its upper neighbour or its pin, by mode. Assumes the neighbours at the ends
// are replaced by the serial inputs in the parent.
module usr_bit_cell
    import usr_pkg::*;
(
    input  logic      clk,
    input  logic      clr_n,
    input  usr_mode_t mode,
    input  logic      from_lo,
    input  logic      from_hi,
    input  logic      pin_d,
    output logic      q
);
    // Purpose: the bit register with asynchronous clear and a four-way mode mux.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            q <= 1'b0;
        end else begin
            case (mode)
                MODE_HOLD: q <= q;
                MODE_SHUP: q <= from_lo;
                MODE_SHDN: q <= from_hi;
                MODE_LOAD: q <= pin_d;
                default:   q <= q;
            endcase
        end
    end
endmodule

// File: rtl/univ_shift_reg.sv
// Universal shift register with shared tri-state data pins.
// Assumes W >= 2 and that an outside agent drives pio only while drivers are off.
module univ_shift_reg
    import usr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic [1:0]   sel,
    input  logic         ser_in_lo,
    input  logic         ser_in_hi,
    input  logic         oe_a_n,
    input  logic         oe_b_n,
    inout  wire  [W-1:0] pio,
    output logic         ser_out_lo,
    output logic         ser_out_hi
);
    localparam int MSB = W - 1;

    usr_mode_t    mode;
    logic         drv_en;
    logic [W-1:0] q_bus;

    usr_ctrl u_ctrl (
        .sel    (sel),
        .oe_a_n (oe_a_n),
        .oe_b_n (oe_b_n),
        .mode   (mode),
        .drv_en (drv_en)
    );

    // Purpose: one cell per bit, with the serial inputs standing in at the ends.
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic lo_src;
        logic hi_src;
        if (i == 0) begin : g_lo_end
            assign lo_src = ser_in_lo;
        end else begin : g_lo_mid
            assign lo_src = q_bus[i-1];
        end
        if (i == MSB) begin : g_hi_end
            assign hi_src = ser_in_hi;
        end else begin : g_hi_mid
            assign hi_src = q_bus[i+1];
        end
        usr_bit_cell u_cell (
            .clk     (clk),
            .clr_n   (clr_n),
            .mode    (mode),
            .from_lo (lo_src),
            .from_hi (hi_src),
            .pin_d   (pio[i]),
            .q       (q_bus[i])
        );
    end

    // Purpose: tri-state drive of the shared pins.
    assign pio = drv_en ? q_bus : {W{1'bz}};

    // Purpose: end bits always visible for cascading.
    assign ser_out_lo = q_bus[0];
    assign ser_out_hi = q_bus[MSB];
endmodule

// File: rtl/usr_chk.sv
// Checker for the universal shift register, bound into every instance.
// Assumes it sees the top ports plus the internal register bus.
module usr_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         clr_n,
    input logic [1:0]   sel,
    input logic         ser_in_lo,
    input logic         ser_in_hi,
    input logic [W-1:0] pio,
    input logic [W-1:0] q_bus,
    input logic         drv_en
);
    // R2
    hold_keeps_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (sel == 2'b00) |=> (q_bus == $past(q_bus)));
    // R3
    shift_up_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (sel == 2'b01) |=> (q_bus == {$past(q_bus[W-2:0]), $past(ser_in_lo)}));
    // R4
    shift_down_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (sel == 2'b10) |=> (q_bus == {$past(ser_in_hi), $past(q_bus[W-1:1])}));
    // R5
    load_capture_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (sel == 2'b11) |=> (q_bus == $past(pio)));
    // R6
    load_release_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (sel == 2'b11) |-> !drv_en);
    // R8
    clear_wins_chk: assert property (@(posedge clk)
        !clr_n |-> (q_bus == '0));
endmodule

bind univ_shift_reg usr_chk #(.W(W)) u_chk (
    .clk       (clk),
    .clr_n     (clr_n),
    .sel       (sel),
    .ser_in_lo (ser_in_lo),
    .ser_in_hi (ser_in_hi),
    .pio       (pio),
    .q_bus     (q_bus),
    .drv_en    (drv_en)
);

// File: tb/univ_shift_reg_tb.sv
module univ_shift_reg_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         clr_n = 1'b0;
    logic [1:0]   sel = 2'b00;
    logic         ser_in_lo = 1'b0;
    logic         ser_in_hi = 1'b0;
    logic         oe_a_n = 1'b1;
    logic         oe_b_n = 1'b1;
    logic         tb_en = 1'b0;
    logic [W-1:0] tb_val = '0;
    wire  [W-1:0] pio;
    logic         ser_out_lo;
    logic         ser_out_hi;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    logic [W-1:0] model = '0;

    assign pio = tb_en ? tb_val : {W{1'bz}};

    univ_shift_reg #(.W(W)) u_dut (
        .clk        (clk),
        .clr_n      (clr_n),
        .sel        (sel),
        .ser_in_lo  (ser_in_lo),
        .ser_in_hi  (ser_in_hi),
        .oe_a_n     (oe_a_n),
        .oe_b_n     (oe_b_n),
        .pio        (pio),
        .ser_out_lo (ser_out_lo),
        .ser_out_hi (ser_out_hi)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic string mode_req(input logic [1:0] s);
        case (s)
            2'b00:   return "R2";
            2'b01:   return "R3";
            2'b10:   return "R4";
            default: return "R5";
        endcase
    endfunction

    function automatic bit dut_drives();
        return !oe_a_n && !oe_b_n && (sel != 2'b11);
    endfunction

    // Compare all visible outputs against the model.
    task automatic compare_all(input string req);
        chk({req, "/R7 lo"}, {{(W-1){1'b0}}, ser_out_lo}, {{(W-1){1'b0}}, model[0]});
        chk({req, "/R7 hi"}, {{(W-1){1'b0}}, ser_out_hi}, {{(W-1){1'b0}}, model[W-1]});
        if (dut_drives()) chk({req, "/R6 drive"}, pio, model);
        else if (tb_en)   chk({req, "/R6 release"}, pio, tb_val);
    endtask

    // One clock: apply at negedge, update model after posedge, compare at next negedge.
    task automatic step(input logic [1:0] s, input logic oa, input logic ob,
                        input logic lo, input logic hi, input logic [W-1:0] v);
        sel = s; oe_a_n = oa; oe_b_n = ob; ser_in_lo = lo; ser_in_hi = hi;
        tb_val = v;
        tb_en = !dut_drives();
        @(posedge clk);
        #0;
        if (clr_n) begin
            case (s)
                2'b01: model = {model[W-2:0], lo};
                2'b10: model = {hi, model[W-1:1]};
                2'b11: model = v;
                default: model = model;
            endcase
        end
        @(negedge clk);
        compare_all(mode_req(s));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs cleared under reset before any release
        chk("R1 reset", {ser_out_hi, ser_out_lo}, 2'b00);
        clr_n = 1'b1;
        step(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, '0);
        chk("R6 reset pins", pio, '0);
        // R5: load a pattern, then show it with enables on
        step(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5);
        step(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, '0);
        chk("R5 loaded", pio, 8'hA5);
        // R3: shift up with ones
        step(2'b01, 1'b0, 1'b0, 1'b1, 1'b0, '0);
        chk("R3 shift up", pio, 8'h4B);
        // R4: shift down with one
        step(2'b10, 1'b0, 1'b0, 1'b0, 1'b1, '0);
        chk("R4 shift down", pio, 8'hA5);
        // R6/R7: disabled pins, outside value read back, serial ends still visible
        step(2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h3C);
        chk("R6 oe_a off", pio, 8'h3C);
        step(2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 8'hC3);
        chk("R7 lo off", {7'd0, ser_out_lo}, 8'h00);
        step(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, '0);
        chk("R2 after off", pio, 8'h4A);
        // R1: clear between edges acts at once
        #1 clr_n = 1'b0;
        #0.5;
        model = '0;
        chk("R1 async", {ser_out_hi, ser_out_lo}, 2'b00);
        chk("R1 pins", pio, '0);
        // R8: edge during clear with an active shift keeps zero
        @(negedge clk);
        sel = 2'b01; ser_in_lo = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R8 clear wins", pio, '0);
        clr_n = 1'b1;
        // Mixed stimulus against the model
        for (int k = 0; k < 600; k++) begin
            logic [31:0] r;
            r = $urandom;
            if (r[31:28] == 4'h0) begin
                #1 clr_n = 1'b0;
                model = '0;
                #0.5 compare_all("R1");
                @(negedge clk);
                clr_n = 1'b1;
            end
            step(r[1:0], r[2] & r[3], r[4] & r[5], r[6], r[7], r[15:8]);
        end
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule